// File: doc/BRIEF.md
# Rotate-Then-Extend Datapath Unit

This unit sits in an execute stage and turns one 32-bit source operand into a 32-bit extended result. The source word is first rotated right by a whole number of bytes (0, 8, 16 or 24 bits). A field is then taken from the rotated word and widened. The field is a byte, a halfword, or a pair of bytes that land in two independent 16-bit lanes, and it is either sign-filled or zero-filled.

Operands arrive on a valid strobe together with an operation code, a rotate select, a condition-pass bit and the destination and source register indices. The unit accepts one operation on every cycle and applies no back-pressure, so no ready signal exists. The result is registered. A write-enable goes out with the result, one cycle after the operand was presented. An illegal-operand flag marks operations that must not commit: reserved codes, or a register index that is barred as an operand. Status flags are never produced.

Top module: `rotext_unit`

## Requirements
- R1: The source word is rotated right by `rot_sel` × 8 bits (0, 8, 16 or 24) before any field is taken.
- R2: Codes 0 (signed) and 3 (unsigned) take bits [7:0] of the rotated word into a 32-bit result. Code 0 copies bit 7 into bits [31:8], and code 3 clears bits [31:8].
- R3: Codes 1 (signed) and 4 (unsigned) take bits [15:0] of the rotated word. Code 1 copies bit 15 into bits [31:16], and code 4 clears bits [31:16].
- R4: Codes 2 (signed) and 5 (unsigned) place bits [7:0] of the rotated word, extended to 16 bits, in result[15:0]. They place bits [23:16], extended to 16 bits, in result[31:16]. Each lane is extended independently of the other.
- R5: The result, write-enable and illegal flag change one clock after `in_valid` is sampled high. With `in_valid` low, the result holds and write-enable and illegal are low on the next cycle.
- R6: `res_wen` is high exactly when the operation was valid, had `cond_pass` high, and was not illegal.
- R7: A valid operation whose `rd_idx` or `rm_idx` is 13 or 15 raises `res_illegal` and keeps `res_wen` low.
- R8: Codes 6 and 7 are reserved. A valid reserved operation raises `res_illegal`, keeps `res_wen` low and loads a zero result.
- R9: A synchronous active-high reset clears `res_data`, `res_wen` and `res_illegal`.
- R10: A valid operation with `cond_pass` low still loads its computed result. It leaves `res_wen` low and does not by itself raise `res_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe, one operation per cycle |
| op_sel | input | 3 | Operation code (0..5 legal, 6..7 reserved) |
| rot_sel | input | 2 | Rotate-right amount in bytes |
| cond_pass | input | 1 | Condition already evaluated as true |
| rd_idx | input | 4 | Destination register index |
| rm_idx | input | 4 | Source register index |
| src_word | input | 32 | Source operand |
| res_data | output | 32 | Registered extended result |
| res_wen | output | 1 | Registered write-enable for `res_data` |
| res_illegal | output | 1 | Registered illegal-operand flag |

## Verification
The bound checker watches the control side on every cycle. It checks that the outputs are clear after reset, and that write-enable never coincides with the illegal flag and only follows a valid operation with a passing condition. It also checks that a barred index or a reserved code always flags and never writes, and that an idle cycle holds the result. The data values cannot be seen by a property without repeating the datapath. The bench's sweeps show the rotation amount, the field positions, the sign or zero fill, and the independence of the two dual lanes. They cover every operation and rotation over all byte values and a set of edge words.

// File: rtl/rotext_pkg.sv
package rotext_pkg;

  typedef enum logic [2:0] {
    OP_SBYTE = 3'd0,
    OP_SHALF = 3'd1,
    OP_SDUAL = 3'd2,
    OP_ZBYTE = 3'd3,
    OP_ZHALF = 3'd4,
    OP_ZDUAL = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } rotext_op_e;

  typedef enum logic [1:0] {
    FLD_BYTE = 2'd0,
    FLD_HALF = 2'd1,
    FLD_DUAL = 2'd2
  } field_e;

  typedef struct packed {
    logic   legal;
    logic   signed_fill;
    field_e field;
  } ext_ctl_t;

  function automatic ext_ctl_t decode_op(input logic [2:0] op);
    ext_ctl_t c;
    c.legal       = 1'b1;
    c.signed_fill = 1'b0;
    c.field       = FLD_BYTE;
    case (op)
      OP_SBYTE: begin c.signed_fill = 1'b1; c.field = FLD_BYTE; end
      OP_SHALF: begin c.signed_fill = 1'b1; c.field = FLD_HALF; end
      OP_SDUAL: begin c.signed_fill = 1'b1; c.field = FLD_DUAL; end
      OP_ZBYTE: c.field = FLD_BYTE;
      OP_ZHALF: c.field = FLD_HALF;
      OP_ZDUAL: c.field = FLD_DUAL;
      default:  c.legal = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rotext_rotator.sv
module rotext_rotator #(
  parameter int DATA_W = 32,
  parameter int UNIT_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic [DATA_W-1:0] src,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] rotated
);
  localparam int N_AMT = 1 << SEL_W;

  logic [DATA_W-1:0] cand [N_AMT];

  // One candidate per rotate amount; the select picks among them.
  for (genvar g = 0; g < N_AMT; g++) begin : g_amt
    localparam int SH = (g * UNIT_W) % DATA_W;
    if (SH == 0) begin : g_none
      assign cand[g] = src;
    end else begin : g_rot
      assign cand[g] = {src[SH-1:0], src[DATA_W-1:SH]};
    end
  end

  assign rotated = cand[sel];
endmodule

// File: rtl/rotext_extractor.sv
module rotext_extractor
  import rotext_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int UNIT_W = 8
) (
  input  logic [DATA_W-1:0] word,
  input  ext_ctl_t          ctl,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = 2 * UNIT_W;
  localparam int LANE_W = DATA_W / 2;
  localparam int N_LANE = 2;

  logic [DATA_W-1:0] byte_res;
  logic [DATA_W-1:0] half_res;
  logic [DATA_W-1:0] dual_res;
  logic              unused_top;

  assign byte_res = {{(DATA_W-UNIT_W){ctl.signed_fill & word[UNIT_W-1]}},
                     word[UNIT_W-1:0]};
  assign half_res = {{(DATA_W-HALF_W){ctl.signed_fill & word[HALF_W-1]}},
                     word[HALF_W-1:0]};

  // Each lane takes the byte at the bottom of its own half of the word.
  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    localparam int LO = l * LANE_W;
    assign dual_res[LO +: LANE_W] =
      {{(LANE_W-UNIT_W){ctl.signed_fill & word[LO+UNIT_W-1]}},
       word[LO +: UNIT_W]};
  end

  assign unused_top = ^word[DATA_W-1:LANE_W+UNIT_W];

  always_comb begin
    unique case (ctl.field)
      FLD_HALF: result = half_res;
      FLD_DUAL: result = dual_res;
      default:  result = byte_res;
    endcase
  end
endmodule

// File: rtl/rotext_operand_check.sv
module rotext_operand_check #(
  parameter int IDX_W     = 4,
  parameter int BAR_IDX_A = 13,
  parameter int BAR_IDX_B = 15
) (
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] rm_idx,
  output logic             barred
);
  localparam logic [IDX_W-1:0] BAR_A = IDX_W'(BAR_IDX_A);
  localparam logic [IDX_W-1:0] BAR_B = IDX_W'(BAR_IDX_B);

  logic [1:0] hit;

  assign hit[0] = (rd_idx == BAR_A) || (rd_idx == BAR_B);
  assign hit[1] = (rm_idx == BAR_A) || (rm_idx == BAR_B);
  assign barred = |hit;
endmodule

// File: rtl/rotext_unit.sv
module rotext_unit
  import rotext_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int UNIT_W    = 8,
  parameter int ROT_W     = 2,
  parameter int IDX_W     = 4,
  parameter int BAR_IDX_A = 13,
  parameter int BAR_IDX_B = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [ROT_W-1:0]  rot_sel,
  input  logic              cond_pass,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  rm_idx,
  input  logic [DATA_W-1:0] src_word,
  output logic [DATA_W-1:0] res_data,
  output logic              res_wen,
  output logic              res_illegal
);
  ext_ctl_t          ctl;
  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] extended;
  logic              barred;
  logic              illegal_d;

  assign ctl = decode_op(op_sel);

  rotext_rotator #(.DATA_W(DATA_W), .UNIT_W(UNIT_W), .SEL_W(ROT_W)) u_rot (
    .src     (src_word),
    .sel     (rot_sel),
    .rotated (rotated)
  );

  rotext_extractor #(.DATA_W(DATA_W), .UNIT_W(UNIT_W)) u_ext (
    .word   (rotated),
    .ctl    (ctl),
    .result (extended)
  );

  rotext_operand_check #(
    .IDX_W(IDX_W), .BAR_IDX_A(BAR_IDX_A), .BAR_IDX_B(BAR_IDX_B)
  ) u_chk_idx (
    .rd_idx (rd_idx),
    .rm_idx (rm_idx),
    .barred (barred)
  );

  assign illegal_d = !ctl.legal || barred;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data    <= '0;
      res_wen     <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      if (in_valid) begin
        res_data <= ctl.legal ? extended : '0;
      end
      res_wen     <= in_valid && cond_pass && !illegal_d;
      res_illegal <= in_valid && illegal_d;
    end
  end
endmodule

// File: rtl/rotext_checker.sv
module rotext_checker #(
  parameter int DATA_W = 32,
  parameter int ROT_W  = 2,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic [ROT_W-1:0]  rot_sel,
  input logic              cond_pass,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [IDX_W-1:0]  rm_idx,
  input logic [DATA_W-1:0] src_word,
  input logic [DATA_W-1:0] res_data,
  input logic              res_wen,
  input logic              res_illegal
);
  logic rst_seen;
  logic unused_ins;

  always_ff @(posedge clk) rst_seen <= rst;

  assign unused_ins = ^{rot_sel, src_word};

  // R9: first cycle out of reset shows cleared outputs
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> (res_data == '0 && !res_wen && !res_illegal));

  // R6: a write never goes out flagged as illegal
  assert_wen_not_illegal_R6: assert property (@(posedge clk) disable iff (rst)
    res_wen |-> !res_illegal);

  // R6: a write only follows a valid operation whose condition passed
  assert_wen_cause_R6: assert property (@(posedge clk) disable iff (rst)
    res_wen |-> ($past(in_valid) && $past(cond_pass)));

  // R7: barred register index flags and blocks the write
  assert_barred_idx_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (rd_idx == 4'd13 || rd_idx == 4'd15 ||
                  rm_idx == 4'd13 || rm_idx == 4'd15))
    |=> (res_illegal && !res_wen));

  // R8: reserved codes flag, block the write and give zero
  assert_reserved_op_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel >= 3'd6) |=> (res_illegal && !res_wen && res_data == '0));

  // R5: an idle cycle holds the result and drops both strobes
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_data) && !res_wen && !res_illegal));
endmodule

bind rotext_unit rotext_checker #(
  .DATA_W(DATA_W), .ROT_W(ROT_W), .IDX_W(IDX_W)
) u_rotext_checker (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .op_sel      (op_sel),
  .rot_sel     (rot_sel),
  .cond_pass   (cond_pass),
  .rd_idx      (rd_idx),
  .rm_idx      (rm_idx),
  .src_word    (src_word),
  .res_data    (res_data),
  .res_wen     (res_wen),
  .res_illegal (res_illegal)
);

// File: tb/test_rotext_unit.sv
`timescale 1ns/1ps
module test_rotext_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  rot_sel = '0;
  logic        cond_pass = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [3:0]  rm_idx = '0;
  logic [31:0] src_word = '0;
  logic [31:0] res_data;
  logic        res_wen;
  logic        res_illegal;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  rotext_unit i_rotext_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .rot_sel(rot_sel), .cond_pass(cond_pass), .rd_idx(rd_idx),
    .rm_idx(rm_idx), .src_word(src_word), .res_data(res_data),
    .res_wen(res_wen), .res_illegal(res_illegal)
  );

  // Arithmetic model of the requirements.
  function automatic logic [31:0] model(input int op, input int rot, input logic [31:0] w);
    logic [63:0] d;
    logic [31:0] r;
    d = {w, w} >> (rot * 8);
    r = d[31:0];
    case (op)
      0: return {{24{r[7]}}, r[7:0]};
      1: return {{16{r[15]}}, r[15:0]};
      2: return {{8{r[23]}}, r[23:16], {8{r[7]}}, r[7:0]};
      3: return {24'h0, r[7:0]};
      4: return {16'h0, r[15:0]};
      5: return {8'h0, r[23:16], 8'h0, r[7:0]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int op, input int rot);
    if (op >= 6) return "R8";
    if (rot != 0) return "R1";
    if (op == 0 || op == 3) return "R2";
    if (op == 1 || op == 4) return "R3";
    return "R4";
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs updated.
  task automatic apply(input logic v, input int op, input int rot, input logic cp,
                       input int rd, input int rm, input logic [31:0] w);
    in_valid  = v;
    op_sel    = 3'(op);
    rot_sel   = 2'(rot);
    cond_pass = cp;
    rd_idx    = 4'(rd);
    rm_idx    = 4'(rm);
    src_word  = w;
    @(negedge clk);
  endtask

  task automatic run_op(input int op, input int rot, input logic [31:0] w);
    string req;
    req = req_of(op, rot);
    apply(1'b1, op, rot, 1'b1, 2, 3, w);
    chk32(req, res_data, model(op, rot, w));
    chk1(op >= 6 ? "R8" : "R6", res_wen, op < 6);
    chk1(op >= 6 ? "R8" : "R6", res_illegal, op >= 6);
  endtask

  logic [31:0] edge_words [12] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h8080_8080, 32'h7F7F_7F7F,
    32'h1234_5678, 32'h89AB_CDEF, 32'h0080_0080, 32'h8000_0000,
    32'h0000_8000, 32'h8001_7F80, 32'hDEAD_BEEF, 32'h00FF_FF00
  };

  initial begin
    logic [31:0] held;
    @(negedge clk);
    @(negedge clk);
    // R9: reset state
    chk32("R9", res_data, 32'h0);
    chk1("R9", res_wen, 1'b0);
    chk1("R9", res_illegal, 1'b0);
    rst = 1'b0;

    // R1 R2 R3 R4 R8: every code and rotation over edge words
    for (int i = 0; i < 12; i++)
      for (int op = 0; op < 8; op++)
        for (int rot = 0; rot < 4; rot++)
          run_op(op, rot, edge_words[i]);

    // Near-exhaustive byte sweep: every byte value in every field position
    for (int b = 0; b < 256; b++)
      for (int op = 0; op < 6; op++)
        for (int rot = 0; rot < 4; rot++)
          run_op(op, rot, {8'(b) ^ 8'h5A, 8'(b), ~8'(b), 8'(b) ^ 8'hC3});

    // R7 and R6: index sweep with condition on and off
    for (int rd = 0; rd < 16; rd++)
      for (int rm = 0; rm < 16; rm++)
        for (int cp = 0; cp < 2; cp++) begin
          logic bad;
          bad = (rd == 13 || rd == 15 || rm == 13 || rm == 15);
          apply(1'b1, 3, 0, 1'(cp), rd, rm, 32'h0000_00A5);
          chk1("R7", res_illegal, bad);
          chk1("R6", res_wen, !bad && cp == 1);
        end

    // R10: condition low still loads the result, no write, no flag
    apply(1'b1, 1, 2, 1'b0, 4, 5, 32'hC001_0000);
    chk32("R10", res_data, 32'hFFFF_C001);
    chk1("R10", res_wen, 1'b0);
    chk1("R10", res_illegal, 1'b0);

    // R5: idle cycles hold the result
    apply(1'b1, 5, 1, 1'b1, 1, 2, 32'h8899_AABB);
    held = model(5, 1, 32'h8899_AABB);
    chk32("R5", res_data, held);
    apply(1'b0, 0, 0, 1'b1, 1, 2, 32'h1111_1111);
    chk32("R5", res_data, held);
    chk1("R5", res_wen, 1'b0);
    chk1("R5", res_illegal, 1'b0);
    apply(1'b0, 7, 3, 1'b0, 13, 15, 32'hFFFF_FFFF);
    chk32("R5", res_data, held);
    chk1("R5", res_illegal, 1'b0);

    // R9: reset in mid-run clears a live write
    apply(1'b1, 4, 0, 1'b1, 1, 2, 32'h0000_BEEF);
    chk1("R9", res_wen, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk32("R9", res_data, 32'h0);
    chk1("R9", res_wen, 1'b0);
    chk1("R9", res_illegal, 1'b0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule